// File: doc/BRIEF.md
# Transmit Descriptor Ring Engine

This block sends frames from a small circular ring of transmit descriptors. Each descriptor holds a buffer address, a byte count and a status byte. Software fills a descriptor through a write port and sets its ownership flag. The engine checks the descriptor at its current ring index. When it owns that entry, it fetches the buffer one byte at a time from an external byte-addressed packet memory and drives the bytes onto a valid/ready stream.

When the stream accepts the last byte of the buffer, the engine clears the ownership flag, which hands the descriptor back to software. It can also raise a one-cycle completion pulse, and it then moves to the next ring entry.

The length is stored as a 15-bit negative two's-complement number. The top bit of the count word requests the completion pulse. The engine reports a transmit underflow when packet memory cannot supply the next byte of a frame that has already started.

Top module: `txring_dma`

## Requirements
- R1: After reset, `out_valid`, `done_irq` and `tx_underflow` are low, and every descriptor reads back a status of 0x00.
- R2: The engine sends nothing while the descriptor at its current index has status bit 7 (ownership) clear. Writing such a descriptor leaves its status unchanged.
- R3: The buffer start address is {high_byte[3:0], low_word}, a 20-bit value. Bits 7:4 of the high byte have no effect. Byte k of a frame is read from start+k modulo 2^20.
- R4: The frame length is (~count + 1) & 0x7FFF. Exactly that many bytes are sent.
- R5: A descriptor whose decoded length is zero sends no bytes. It is still handed back, the ring index still advances, and `done_irq` pulses when count bit 15 is set.
- R6: `out_last` is high on the final byte of a descriptor when status bit 0 (end of packet) is set, and low on every other byte. Status bit 1 (start of packet) has no effect on the stream.
- R7: While `out_valid` is high and `out_ready` is low, `out_valid`, `out_data` and `out_last` hold their values.
- R8: On the clock edge where the final byte is accepted, status bit 7 clears and the other status bits are kept. In the next cycle `done_irq` is high for one cycle if count bit 15 was set.
- R9: Descriptors are serviced in index order, and the index wraps to 0 after the last ring entry.
- R10: If a byte that is not a descriptor's final byte is accepted while `pm_ok` is low, `tx_underflow` is high for the next cycle. `out_valid` stays low until `pm_ok` returns.
- R11: If a host write and a hand-back target the same descriptor in the same cycle, the host write takes effect in full.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| hw_we | input | 1 | Host descriptor write strobe |
| hw_idx | input | IDX_W | Ring index to write |
| hw_addr_lo | input | 16 | Buffer address bits 15:0 |
| hw_addr_hi | input | 8 | Buffer address high byte (low nibble used) |
| hw_status | input | 8 | Status byte: bit 7 ownership, bit 1 start, bit 0 end |
| hw_count | input | 16 | Negative length in bits 14:0, completion request in bit 15 |
| hr_idx | input | IDX_W | Ring index to read back |
| hr_status | output | 8 | Status byte of descriptor `hr_idx` |
| pm_addr | output | 20 | Packet memory byte address |
| pm_data | input | 8 | Packet memory byte at `pm_addr` (same cycle) |
| pm_ok | input | 1 | Packet memory byte available this cycle |
| out_valid | output | 1 | Output byte valid |
| out_ready | input | 1 | Sink accepts the byte |
| out_data | output | 8 | Output byte |
| out_last | output | 1 | Final byte of a frame |
| done_irq | output | 1 | One-cycle completion pulse |
| tx_underflow | output | 1 | One-cycle underflow pulse |

## Verification
The two functions that can fall in the same cycle are the engine's hand-back of a finished descriptor and a host write to that same ring slot. The bench holds `out_ready` low while the final byte of a frame is valid. It then raises `out_ready` and issues a fresh owned write to the same index in one cycle, so the hand-back edge and the host write coincide. The bench judges the result by reading back the status: it must show the newly written value with ownership set. The replacement frame must also go out in ring order after the frame already queued in the other slot.

// File: rtl/txring_pkg.sv
`timescale 1ns/1ps
// txring_pkg: shared widths, status bit positions, descriptor storage type
// and the two decode helpers used by the ring engine.
package txring_pkg;
    localparam int ADDR_W  = 20;
    localparam int BYTE_W  = 8;
    localparam int LEN_W   = 15;
    localparam int OWN_BIT = 7;
    localparam int EOP_BIT = 0;
    localparam int IRQ_BIT = 15;

    // Stored form of one descriptor; only the used nibble of the high byte is kept.
    typedef struct packed {
        logic [15:0] lo;
        logic [3:0]  hi;
        logic [7:0]  st;
        logic [15:0] cnt;
    } txdesc_t;

    // Decode a negative 15-bit count into a positive byte length.
    function automatic logic [LEN_W-1:0] frame_len(input logic [15:0] c);
        logic [LEN_W-1:0] inv;
        inv = ~c[LEN_W-1:0];
        return inv + 1'b1;
    endfunction

    // Form the 20-bit linear start address of a buffer.
    function automatic logic [ADDR_W-1:0] buf_base(input txdesc_t d);
        return {d.hi, d.lo};
    endfunction
endpackage

// File: rtl/txdesc_store.sv
`timescale 1ns/1ps
// txdesc_store: register file of RING descriptors.
// The host write port replaces a whole entry. The engine's hand-back clears
// only the ownership bit, and the host write wins when both target one entry.
// Assumes RING is a power of two and at least 2.
module txdesc_store
    import txring_pkg::*;
#(
    parameter int RING = 2,
    localparam int IDX_W = $clog2(RING)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  hw_we,
    input  logic [IDX_W-1:0]      hw_idx,
    input  txdesc_t               hw_desc,
    input  logic                  ret_we,
    input  logic [IDX_W-1:0]      ret_idx,
    input  logic [IDX_W-1:0]      eng_idx,
    output logic                  eng_own,
    output logic                  eng_eop,
    output logic [ADDR_W-1:0]     eng_base,
    output logic [15:0]           eng_cnt,
    input  logic [IDX_W-1:0]      hr_idx,
    output logic [7:0]            hr_status,
    output logic [RING-1:0]       own_vec
);
    txdesc_t ent [RING];

    for (genvar i = 0; i < RING; i++) begin : g_ent
        txdesc_t slot;
        // Per-entry update: host write first, then hand-back of ownership.
        always_ff @(posedge clk) begin
            if (!rst_n)
                slot <= '0;
            else if (hw_we && hw_idx == IDX_W'(i))
                slot <= hw_desc;
            else if (ret_we && ret_idx == IDX_W'(i))
                slot.st[OWN_BIT] <= 1'b0;
        end
        assign ent[i]     = slot;
        assign own_vec[i] = slot.st[OWN_BIT];
    end

    // Engine view of the current entry, narrowed to the fields it decodes.
    always_comb begin
        eng_own  = ent[eng_idx].st[OWN_BIT];
        eng_eop  = ent[eng_idx].st[EOP_BIT];
        eng_base = buf_base(ent[eng_idx]);
        eng_cnt  = ent[eng_idx].cnt;
    end

    assign hr_status = ent[hr_idx].st;
endmodule

// File: rtl/txbyte_stage.sv
`timescale 1ns/1ps
// txbyte_stage: single output register for the byte stream.
// It holds data and last while the sink stalls, and can be reloaded in the
// same cycle that the held byte is accepted.
module txbyte_stage
    import txring_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [BYTE_W-1:0] din,
    input  logic              lin,
    input  logic              out_ready,
    output logic              out_valid,
    output logic [BYTE_W-1:0] out_data,
    output logic              out_last,
    output logic              accept
);
    assign accept = out_valid && out_ready;

    // Output register: load wins over drain so back-to-back bytes have no bubble.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_data  <= '0;
            out_last  <= 1'b0;
        end else if (load) begin
            out_valid <= 1'b1;
            out_data  <= din;
            out_last  <= lin;
        end else if (accept) begin
            out_valid <= 1'b0;
            out_last  <= 1'b0;
        end
    end
endmodule

// File: rtl/txring_seq.sv
`timescale 1ns/1ps
// txring_seq: ring sequencer. It checks the ownership bit at the current
// index, decodes length and address, steps through the buffer, hands the
// descriptor back and advances the index.
// Assumes the packet memory returns pm_data for pm_addr in the same cycle.
module txring_seq
    import txring_pkg::*;
#(
    parameter int RING = 2,
    localparam int IDX_W = $clog2(RING)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              eng_own,
    input  logic              eng_eop,
    input  logic [ADDR_W-1:0] eng_base,
    input  logic [15:0]       eng_cnt,
    output logic [IDX_W-1:0]  eng_idx,
    output logic [ADDR_W-1:0] pm_addr,
    input  logic              pm_ok,
    input  logic              stage_valid,
    input  logic              accept,
    output logic              load,
    output logic              load_last,
    output logic              ret_we,
    output logic [IDX_W-1:0]  ret_idx,
    output logic              done_irq,
    output logic              tx_underflow
);
    typedef enum logic {S_IDLE, S_SEND} seq_e;

    seq_e              state;
    logic [IDX_W-1:0]  idx;
    logic [ADDR_W-1:0] ptr;
    logic [LEN_W-1:0]  rem;
    logic              want_irq;
    logic              eop_q;
    logic [LEN_W-1:0]  desc_len;
    logic              take, skip, finish, slot_free;

    // Decode of the entry under the index and the per-cycle transfer decisions.
    always_comb begin
        desc_len  = frame_len(eng_cnt);
        take      = (state == S_IDLE) && eng_own;
        skip      = take && (desc_len == '0);
        slot_free = !stage_valid || accept;
        load      = (state == S_SEND) && slot_free && (rem != '0) && pm_ok;
        load_last = eop_q && (rem == LEN_W'(1));
        finish    = (state == S_SEND) && (rem == '0) && accept;
        ret_we    = skip || finish;
    end

    assign eng_idx = idx;
    assign ret_idx = idx;
    assign pm_addr = ptr;

    // Sequencer state, buffer pointer, remaining count and event pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state        <= S_IDLE;
            idx          <= '0;
            ptr          <= '0;
            rem          <= '0;
            want_irq     <= 1'b0;
            eop_q        <= 1'b0;
            done_irq     <= 1'b0;
            tx_underflow <= 1'b0;
        end else begin
            done_irq     <= (skip && eng_cnt[IRQ_BIT]) || (finish && want_irq);
            tx_underflow <= (state == S_SEND) && accept && (rem != '0) && !pm_ok;
            case (state)
                S_IDLE: begin
                    if (skip) begin
                        idx <= idx + 1'b1;
                    end else if (take) begin
                        ptr      <= eng_base;
                        rem      <= desc_len;
                        want_irq <= eng_cnt[IRQ_BIT];
                        eop_q    <= eng_eop;
                        state    <= S_SEND;
                    end
                end
                S_SEND: begin
                    if (load) begin
                        ptr <= ptr + 1'b1;
                        rem <= rem - 1'b1;
                    end
                    if (finish) begin
                        idx   <= idx + 1'b1;
                        state <= S_IDLE;
                    end
                end
                default: state <= S_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/txring_dma.sv
`timescale 1ns/1ps
// txring_dma: top of the transmit descriptor ring engine.
// It ties the descriptor store, the ring sequencer and the output stage
// together. Bits 7:4 of the address high byte are dropped on entry.
module txring_dma
    import txring_pkg::*;
#(
    parameter int RING = 2,
    localparam int IDX_W = $clog2(RING)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hw_we,
    input  logic [IDX_W-1:0]  hw_idx,
    input  logic [15:0]       hw_addr_lo,
    input  logic [7:0]        hw_addr_hi,
    input  logic [7:0]        hw_status,
    input  logic [15:0]       hw_count,
    input  logic [IDX_W-1:0]  hr_idx,
    output logic [7:0]        hr_status,
    output logic [ADDR_W-1:0] pm_addr,
    input  logic [BYTE_W-1:0] pm_data,
    input  logic              pm_ok,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [BYTE_W-1:0] out_data,
    output logic              out_last,
    output logic              done_irq,
    output logic              tx_underflow
);
    txdesc_t           hw_desc;
    logic              eng_own, eng_eop;
    logic [ADDR_W-1:0] eng_base;
    logic [15:0]       eng_cnt;
    logic [IDX_W-1:0]  eng_idx;
    logic              ret_we;
    logic [IDX_W-1:0]  ret_idx;
    logic [RING-1:0]   own_vec;
    logic              load, load_last, accept;
    logic              unused_hi_nibble;

    // Pack the host write into storage form; the ignored nibble goes nowhere.
    always_comb begin
        hw_desc.lo  = hw_addr_lo;
        hw_desc.hi  = hw_addr_hi[3:0];
        hw_desc.st  = hw_status;
        hw_desc.cnt = hw_count;
    end
    assign unused_hi_nibble = ^hw_addr_hi[7:4];

    txdesc_store #(.RING(RING)) u_store (
        .clk(clk), .rst_n(rst_n),
        .hw_we(hw_we), .hw_idx(hw_idx), .hw_desc(hw_desc),
        .ret_we(ret_we), .ret_idx(ret_idx),
        .eng_idx(eng_idx), .eng_own(eng_own), .eng_eop(eng_eop),
        .eng_base(eng_base), .eng_cnt(eng_cnt),
        .hr_idx(hr_idx), .hr_status(hr_status), .own_vec(own_vec)
    );

    txring_seq #(.RING(RING)) u_seq (
        .clk(clk), .rst_n(rst_n),
        .eng_own(eng_own), .eng_eop(eng_eop), .eng_base(eng_base), .eng_cnt(eng_cnt),
        .eng_idx(eng_idx), .pm_addr(pm_addr), .pm_ok(pm_ok),
        .stage_valid(out_valid), .accept(accept),
        .load(load), .load_last(load_last),
        .ret_we(ret_we), .ret_idx(ret_idx),
        .done_irq(done_irq), .tx_underflow(tx_underflow)
    );

    txbyte_stage u_stage (
        .clk(clk), .rst_n(rst_n),
        .load(load), .din(pm_data), .lin(load_last),
        .out_ready(out_ready), .out_valid(out_valid),
        .out_data(out_data), .out_last(out_last), .accept(accept)
    );
endmodule

// File: rtl/txring_chk.sv
`timescale 1ns/1ps
// txring_chk: timing properties of the ring engine, bound to txring_dma.
module txring_chk
    import txring_pkg::*;
#(
    parameter int RING = 2,
    localparam int IDX_W = $clog2(RING)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              out_valid,
    input logic              out_ready,
    input logic [BYTE_W-1:0] out_data,
    input logic              out_last,
    input logic              tx_underflow,
    input logic              done_irq,
    input logic              hw_we,
    input logic [IDX_W-1:0]  hw_idx,
    input logic [7:0]        hw_status,
    input logic              ret_we,
    input logic [IDX_W-1:0]  ret_idx,
    input logic [RING-1:0]   own_vec
);
    p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_last));

    p_gap_r10: assert property (@(posedge clk) disable iff (!rst_n)
        tx_underflow |-> !out_valid);

    p_handback_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ret_we && !(hw_we && hw_idx == ret_idx) |=> !own_vec[$past(ret_idx)]);

    p_irq_src_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done_irq |-> $past(ret_we));

    p_host_wins_r11: assert property (@(posedge clk) disable iff (!rst_n)
        hw_we && hw_status[OWN_BIT] |=> own_vec[$past(hw_idx)]);

    p_ring_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ret_we |=> ret_idx == IDX_W'($past(ret_idx) + 1'b1));
endmodule

bind txring_dma txring_chk #(.RING(RING)) u_chk (
    .clk(clk), .rst_n(rst_n),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data), .out_last(out_last),
    .tx_underflow(tx_underflow), .done_irq(done_irq),
    .hw_we(hw_we), .hw_idx(hw_idx), .hw_status(hw_status),
    .ret_we(ret_we), .ret_idx(ret_idx), .own_vec(own_vec)
);

// File: tb/sim_txring_dma.sv
`timescale 1ns/1ps
module sim_txring_dma;
    localparam int IW = 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2 clk = ~clk;

    logic          hw_we = 1'b0;
    logic [IW-1:0] hw_idx = '0;
    logic [15:0]   hw_addr_lo = '0;
    logic [7:0]    hw_addr_hi = '0;
    logic [7:0]    hw_status = '0;
    logic [15:0]   hw_count = '0;
    logic [IW-1:0] hr_idx = '0;
    logic [7:0]    hr_status;
    logic [19:0]   pm_addr;
    logic [7:0]    pm_data;
    logic          pm_ok = 1'b1;
    logic          out_valid, out_last, done_irq, tx_underflow;
    logic          out_ready = 1'b1;
    logic [7:0]    out_data;

    function automatic logic [7:0] pbyte(input logic [19:0] a);
        return a[7:0] ^ {a[11:8], a[19:16]} ^ 8'h5A;
    endfunction
    assign pm_data = pbyte(pm_addr);

    txring_dma #(.RING(2)) u0 (
        .clk(clk), .rst_n(rst_n), .hw_we(hw_we), .hw_idx(hw_idx),
        .hw_addr_lo(hw_addr_lo), .hw_addr_hi(hw_addr_hi), .hw_status(hw_status),
        .hw_count(hw_count), .hr_idx(hr_idx), .hr_status(hr_status),
        .pm_addr(pm_addr), .pm_data(pm_data), .pm_ok(pm_ok),
        .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
        .out_last(out_last), .done_irq(done_irq), .tx_underflow(tx_underflow)
    );

    typedef struct { logic [7:0] d; bit last; bit fin; bit ie; } exp_t;
    exp_t q[$];

    int n_chk = 0, n_fail = 0, irq_seen = 0, irq_exp = 0;
    int n_bytes = 0, exp_bytes = 0, cyc = 0;
    int rdy_mode = 0, pm_mode = 0;
    logic [15:0] lfsr = 16'hACE1;
    bit uf_exp = 0, irqf_exp = 0, prev_hold = 0;
    logic [7:0] prev_d = '0;

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    endtask

    // Watchdog: a hung run is a failed check.
    always @(posedge clk) begin
        cyc++;
        if (cyc == 150000) begin
            chk(1'b0, "R9", "watchdog cycles", cyc, 0);
            finish_run();
        end
    end

    // Stimulus patterns for the sink and the packet memory.
    always @(posedge clk) begin
        lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        #1;
        if (rdy_mode == 0) out_ready = 1'b1;
        else if (rdy_mode == 1) out_ready = lfsr[3] | lfsr[7];
        if (pm_mode == 0) pm_ok = 1'b1;
        else pm_ok = lfsr[2] ^ lfsr[9];
    end

    // Reference model: compare every cycle against the expected byte queue.
    always @(negedge clk) begin
        if (rst_n) begin
            chk(tx_underflow === uf_exp, "R10", "underflow pulse", int'(tx_underflow), int'(uf_exp));
            if (irqf_exp) chk(done_irq === 1'b1, "R8", "completion pulse", int'(done_irq), 1);
            if (done_irq) irq_seen++;
            if (prev_hold) chk(out_valid && out_data == prev_d, "R7", "held byte", int'(out_data), int'(prev_d));
            if (out_valid) begin
                if (q.size() == 0) chk(1'b0, "R2", "unexpected byte", int'(out_data), 0);
                else begin
                    chk(out_data == q[0].d, "R3", "byte value", int'(out_data), int'(q[0].d));
                    chk(out_last == q[0].last, "R6", "last flag", int'(out_last), int'(q[0].last));
                end
            end
            prev_hold = out_valid && !out_ready;
            prev_d    = out_data;
            uf_exp    = 0;
            irqf_exp  = 0;
            if (out_valid && out_ready && q.size() > 0) begin
                exp_t h;
                h = q.pop_front();
                uf_exp   = !h.fin && !pm_ok;
                irqf_exp = h.fin && h.ie;
                n_bytes++;
            end
        end
    end

    task automatic expect_desc(input logic [15:0] lo, input logic [7:0] hi, input logic [7:0] st, input logic [15:0] cnt);
        logic [15:0] neg;
        logic [19:0] base;
        int len;
        if (!st[7]) return;
        neg  = (~cnt) + 16'd1;
        len  = int'(neg & 16'h7FFF);
        base = {hi[3:0], lo};
        for (int i = 0; i < len; i++) begin
            exp_t e;
            e.d    = pbyte(base + 20'(i));
            e.fin  = (i == len - 1);
            e.last = e.fin && st[0];
            e.ie   = cnt[15];
            q.push_back(e);
        end
        exp_bytes += len;
        if (cnt[15]) irq_exp++;
    endtask

    task automatic submit(input int idx, input logic [15:0] lo, input logic [7:0] hi, input logic [7:0] st, input logic [15:0] cnt);
        @(posedge clk); #1;
        hw_idx = IW'(idx); hw_addr_lo = lo; hw_addr_hi = hi; hw_status = st; hw_count = cnt;
        hw_we = 1'b1;
        expect_desc(lo, hi, st, cnt);
        @(posedge clk); #1;
        hw_we = 1'b0;
    endtask

    task automatic drain();
        int t = 0;
        while ((q.size() != 0 || out_valid) && t < 20000) begin
            @(posedge clk);
            t++;
        end
        repeat (4) @(posedge clk);
        #1;
    endtask

    task automatic status_is(input int i, input logic [7:0] exp, input string req);
        @(posedge clk); #1;
        hr_idx = IW'(i);
        @(negedge clk);
        chk(hr_status == exp, req, "status byte", int'(hr_status), int'(exp));
    endtask

    initial begin
        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        chk(!out_valid && !done_irq && !tx_underflow, "R1", "outputs after reset",
            int'({out_valid, done_irq, tx_underflow}), 0);
        status_is(0, 8'h00, "R1");
        status_is(1, 8'h00, "R1");

        // R2: descriptor without ownership is left alone.
        submit(0, 16'h0100, 8'h00, 8'h03, 16'h7FFB);
        repeat (20) @(negedge clk);
        chk(!out_valid, "R2", "idle output", int'(out_valid), 0);
        status_is(0, 8'h03, "R2");

        // R4/R8: basic frame with completion request.
        submit(0, 16'h1000, 8'h02, 8'h83, 16'hFFFA);
        drain();
        status_is(0, 8'h03, "R8");

        // R3: junk upper nibble, random sink stalls; slot 1 then wrap (R9).
        rdy_mode = 1;
        submit(1, 16'hFFFE, 8'hF5, 8'h83, 16'h7FFB);
        drain();
        status_is(1, 8'h03, "R9");

        // R6/R3: two-part frame, first part wraps the 20-bit address.
        submit(0, 16'hFFFD, 8'h0F, 8'h82, 16'h7FFA);
        submit(1, 16'h0040, 8'h00, 8'h81, 16'hFFFC);
        drain();
        rdy_mode = 0;

        // R5: zero-length descriptors, with and without completion request.
        submit(0, 16'h0000, 8'h00, 8'h83, 16'h8000);
        @(negedge clk);
        @(negedge clk);
        chk(done_irq === 1'b1, "R5", "zero-length pulse", int'(done_irq), 1);
        status_is(0, 8'h03, "R5");
        submit(1, 16'h0000, 8'h00, 8'h83, 16'h0000);
        repeat (3) @(negedge clk);
        chk(!out_valid, "R5", "zero-length sends nothing", int'(out_valid), 0);
        status_is(1, 8'h03, "R5");

        // R10: packet memory runs dry mid-frame.
        pm_mode = 1;
        submit(0, 16'h2000, 8'h01, 8'h83, 16'hFFF8);
        drain();
        pm_mode = 0;

        // R4: longer frame under random stalls.
        rdy_mode = 1;
        submit(1, 16'h4321, 8'h03, 8'h83, 16'hFED4);
        drain();

        // R11: host write lands on the hand-back edge of the same slot.
        @(posedge clk); #1;
        rdy_mode = 2;
        out_ready = 1'b0;
        submit(0, 16'h3000, 8'h00, 8'h83, 16'h7FFD);
        submit(1, 16'h3100, 8'h00, 8'h83, 16'h7FFC);
        forever begin
            @(posedge clk); #1;
            out_ready = 1'b0;
            if (out_valid && q.size() > 0 && q[0].fin) break;
            out_ready = 1'b1;
        end
        hw_idx = 1'b0; hw_addr_lo = 16'h3200; hw_addr_hi = 8'h00;
        hw_status = 8'h83; hw_count = 16'hFFFE;
        hw_we = 1'b1;
        out_ready = 1'b1;
        expect_desc(16'h3200, 8'h00, 8'h83, 16'hFFFE);
        @(posedge clk); #1;
        hw_we = 1'b0;
        rdy_mode = 0;
        hr_idx = 1'b0;
        @(negedge clk);
        chk(hr_status == 8'h83, "R11", "host write kept", int'(hr_status), 8'h83);
        drain();
        status_is(0, 8'h03, "R11");

        chk(n_bytes == exp_bytes, "R4", "total bytes", n_bytes, exp_bytes);
        chk(irq_seen == irq_exp, "R8", "completion pulses", irq_seen, irq_exp);
        finish_run();
    end
endmodule